// File: doc/BRIEF.md
# Power-Mode Controller with Wake Logic

This block sequences the power state of a small processor core. While the core runs, a sleep-instruction strobe moves it into one of two low-power states. With the idle-enable bit set, the core goes to idle: the CPU clock is gated and the peripheral clock keeps running from the internal oscillator. With the bit clear, the core goes to sleep and both clocks are gated. The block also decides when the core may run again, and whether it should branch to the interrupt vector when it does.

Three things bring the core back to run: an interrupt whose individual enable bit is set, the integrated watchdog timing out, or the external reset. A wake from an interrupt or a time-out is followed by a fixed number of cycles on the free-running internal oscillator before the CPU clock comes back. A watchdog time-out has two meanings. It wakes a core that is idle or asleep, and it raises a reset request for a core that is running.

The block holds the selected clock source. A wake leaves it unchanged, and the reset forces it back to the internal RC oscillator. The idle-enable bit and the global interrupt enable are inputs that the block only reads, so a wake cannot alter them.

Top module: `pwr_seq`

## Requirements
- R1: After a cycle with `rst` high, `mode` is run, `cpu_clk_en` and `per_clk_en` are 1, `clk_src` is 0 (internal RC), and `wake_done`, `vec_req` and `wdt_rst_req` are 0.
- R2: In run, with no wake source pending, a `sleep_op` cycle with `idle_en` = 1 puts `mode` at idle from the next cycle on, with `cpu_clk_en` = 0 and `per_clk_en` = 1.
- R3: In run, with no wake source pending, a `sleep_op` cycle with `idle_en` = 0 puts `mode` at sleep from the next cycle on, with both clock enables 0.
- R4: In idle or sleep, a cycle in which some bit is set in both `irq_flag` and `irq_en` is a wake event, and `mode` is wake in the next cycle. A flag whose enable bit is clear leaves the low-power mode unchanged.
- R5: After a wake event `mode` stays at wake for exactly WAKE_DLY cycles (default 4), with `cpu_clk_en` = 0 and `per_clk_en` = 1. Then `mode` returns to run, and `wake_done` is high for exactly that first run cycle.
- R6: `vec_req` is high together with `wake_done` only when the wake event was an interrupt and `gie` was 1 in the wake-event cycle. Otherwise it stays 0.
- R7: With `wdt_en` = 1, the watchdog times out PRE_LIM*POST_LIM cycles after the cycle in which it was last cleared (default 16). A time-out while in run raises `wdt_rst_req` for one cycle.
- R8: A watchdog time-out in idle or sleep is a wake event that follows R5. It raises no `wdt_rst_req` and no `vec_req`.
- R9: The watchdog count is cleared by `clrwdt_op`, by `sleep_op` in run, and by `clk_lost` while `fscm_en` = 1. A `clk_lost` pulse with `fscm_en` = 0 leaves the count and the time-out cycle unchanged.
- R10: If a wake source (an enabled interrupt flag or a time-out) is pending in the cycle of `sleep_op`, `mode` stays at run.
- R11: `clk_src` takes `sel_d` in the cycle after `sel_wr`. A wake leaves it unchanged, and `rst` sets it to 0.
- R12: `mode` is encoded as 0 = run, 1 = idle, 2 = sleep, 3 = wake delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running internal oscillator clock |
| rst | input | 1 | Synchronous active-high external reset |
| sleep_op | input | 1 | Sleep instruction executed (one cycle) |
| clrwdt_op | input | 1 | Clear-watchdog instruction executed (one cycle) |
| idle_en | input | 1 | Selects idle (1) or sleep (0) on `sleep_op` |
| irq_flag | input | N_IRQ | Interrupt flags |
| irq_en | input | N_IRQ | Individual interrupt enables |
| gie | input | 1 | Global interrupt enable |
| wdt_en | input | 1 | Watchdog counting enable |
| clk_lost | input | 1 | Selected clock source has failed |
| fscm_en | input | 1 | Fail-safe clock monitoring enabled |
| sel_wr | input | 1 | Write strobe for the clock-source select |
| sel_d | input | 2 | New clock-source select value |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| wake_done | output | 1 | First cycle of execution after the wake delay |
| vec_req | output | 1 | Branch to the interrupt vector on resume |
| wdt_rst_req | output | 1 | Watchdog reset request |
| mode | output | 2 | Current power mode (see R12) |
| clk_src | output | 2 | Selected clock source, 0 = internal RC |

## Verification
The hardest case to reach is a watchdog time-out that lands while the core is asleep. It has to wake the core without a reset request and without a vector, and its timing is set by a count the bench cannot see. The bench reaches it by issuing the sleep strobe itself, which also clears the watchdog. That fixes the time-out at a known cycle, so the bench can check the exact cycle of the wake, the length of the delay and the absence of both strobes. The same fixed origin lets the bench show that a lost clock without fail-safe monitoring leaves the time-out where it was, while a clear in the middle pushes it back.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_SLEEP = 2'd2,
        PM_WAKE  = 2'd3
    } pmode_e;

    localparam logic [1:0] SRC_INTRC = 2'b00;

    typedef struct packed {
        logic cpu;
        logic per;
    } clk_en_t;

    // Gating per power mode: the peripheral clock runs during the wake delay.
    function automatic clk_en_t mode_clocks(input pmode_e m);
        clk_en_t c;
        case (m)
            PM_RUN:   c = '{cpu: 1'b1, per: 1'b1};
            PM_IDLE:  c = '{cpu: 1'b0, per: 1'b1};
            PM_SLEEP: c = '{cpu: 1'b0, per: 1'b0};
            default:  c = '{cpu: 1'b0, per: 1'b1};
        endcase
        return c;
    endfunction

    function automatic logic is_low_power(input pmode_e m);
        return (m == PM_IDLE) || (m == PM_SLEEP);
    endfunction

endpackage

// File: rtl/pwr_wdt.sv
module pwr_wdt #(
    parameter int PRE_LIM  = 4,
    parameter int POST_LIM = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic clr,
    output logic to
);
    localparam int PW = (PRE_LIM  > 1) ? $clog2(PRE_LIM)  : 1;
    localparam int QW = (POST_LIM > 1) ? $clog2(POST_LIM) : 1;
    localparam logic [PW-1:0] PRE_TOP  = PW'(PRE_LIM - 1);
    localparam logic [QW-1:0] POST_TOP = QW'(POST_LIM - 1);

    logic [PW-1:0] pre_q;
    logic [QW-1:0] post_q;
    logic          to_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q  <= '0;
            post_q <= '0;
            to_q   <= 1'b0;
        end else begin
            to_q <= 1'b0;
            if (en) begin
                if (pre_q == PRE_TOP) begin
                    pre_q <= '0;
                    if (post_q == POST_TOP) begin
                        post_q <= '0;
                        to_q   <= 1'b1;
                    end else begin
                        post_q <= post_q + 1'b1;
                    end
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end
    end

    assign to = to_q;

    AST_TO_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        to_q |=> !to_q);  // R7
    AST_CLEAR_SILENCES: assert property (@(posedge clk) disable iff (rst)
        clr |=> !to_q);  // R9

endmodule

// File: rtl/pwr_wake_ctl.sv
module pwr_wake_ctl
    import pwr_seq_pkg::*;
#(
    parameter int N_IRQ    = 4,
    parameter int WAKE_DLY = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_op,
    input  logic             idle_en,
    input  logic [N_IRQ-1:0] irq_flag,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             gie,
    input  logic             wdt_to,
    output pmode_e           mode,
    output logic             done,
    output logic             vec
);
    localparam int CW = $clog2(WAKE_DLY + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(WAKE_DLY - 1);

    pmode_e        mode_q;
    logic [CW-1:0] cnt_q;
    logic          vec_pend_q;
    logic          done_q;
    logic          vec_q;
    logic          irq_hit;
    logic          pend;

    assign irq_hit = |(irq_flag & irq_en);
    assign pend    = irq_hit | wdt_to;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= PM_RUN;
            cnt_q      <= '0;
            vec_pend_q <= 1'b0;
            done_q     <= 1'b0;
            vec_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            vec_q  <= 1'b0;
            case (mode_q)
                PM_RUN: begin
                    if (sleep_op && !pend)
                        mode_q <= idle_en ? PM_IDLE : PM_SLEEP;
                end
                PM_IDLE, PM_SLEEP: begin
                    if (pend) begin
                        mode_q     <= PM_WAKE;
                        cnt_q      <= '0;
                        vec_pend_q <= irq_hit & gie;
                    end
                end
                default: begin
                    if (cnt_q == CNT_TOP) begin
                        mode_q <= PM_RUN;
                        done_q <= 1'b1;
                        vec_q  <= vec_pend_q;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign mode = mode_q;
    assign done = done_q;
    assign vec  = vec_q;

    AST_DONE_AFTER_WAKE: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (mode_q == PM_RUN && $past(mode_q) == PM_WAKE));  // R5
    AST_VEC_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        vec_q |-> done_q);  // R6
    AST_NO_ENTRY_PENDING: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_RUN && sleep_op && pend) |=> (mode_q == PM_RUN));  // R10
    AST_LOWPWR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (is_low_power(mode_q) && !pend) |=> $stable(mode_q));  // R4
    AST_WDT_WAKES: assert property (@(posedge clk) disable iff (rst)
        (is_low_power(mode_q) && wdt_to) |=> (mode_q == PM_WAKE));  // R8

endmodule

// File: rtl/pwr_clksel.sv
module pwr_clksel
    import pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_wr,
    input  logic [1:0] sel_d,
    input  pmode_e     mode,
    output logic [1:0] clk_src,
    output logic       cpu_clk_en,
    output logic       per_clk_en
);
    logic [1:0] src_q;
    clk_en_t    gate;

    always_ff @(posedge clk) begin
        if (rst)
            src_q <= SRC_INTRC;
        else if (sel_wr)
            src_q <= sel_d;
    end

    always_comb begin
        gate = mode_clocks(mode);
    end

    assign clk_src    = src_q;
    assign cpu_clk_en = gate.cpu;
    assign per_clk_en = gate.per;

    AST_SRC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sel_wr |=> $stable(src_q));  // R11

endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
    import pwr_seq_pkg::*;
#(
    parameter int N_IRQ    = 4,
    parameter int WAKE_DLY = 4,
    parameter int PRE_LIM  = 4,
    parameter int POST_LIM = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_op,
    input  logic             clrwdt_op,
    input  logic             idle_en,
    input  logic [N_IRQ-1:0] irq_flag,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             gie,
    input  logic             wdt_en,
    input  logic             clk_lost,
    input  logic             fscm_en,
    input  logic             sel_wr,
    input  logic [1:0]       sel_d,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             wake_done,
    output logic             vec_req,
    output logic             wdt_rst_req,
    output logic [1:0]       mode,
    output logic [1:0]       clk_src
);
    pmode_e cur_mode;
    logic   wdt_to;
    logic   wdt_clr;

    assign wdt_clr = clrwdt_op
                   | (sleep_op && cur_mode == PM_RUN)
                   | (clk_lost && fscm_en);

    pwr_wdt #(
        .PRE_LIM  (PRE_LIM),
        .POST_LIM (POST_LIM)
    ) wdt_i (
        .clk (clk),
        .rst (rst),
        .en  (wdt_en),
        .clr (wdt_clr),
        .to  (wdt_to)
    );

    pwr_wake_ctl #(
        .N_IRQ    (N_IRQ),
        .WAKE_DLY (WAKE_DLY)
    ) wake_i (
        .clk      (clk),
        .rst      (rst),
        .sleep_op (sleep_op),
        .idle_en  (idle_en),
        .irq_flag (irq_flag),
        .irq_en   (irq_en),
        .gie      (gie),
        .wdt_to   (wdt_to),
        .mode     (cur_mode),
        .done     (wake_done),
        .vec      (vec_req)
    );

    pwr_clksel clksel_i (
        .clk        (clk),
        .rst        (rst),
        .sel_wr     (sel_wr),
        .sel_d      (sel_d),
        .mode       (cur_mode),
        .clk_src    (clk_src),
        .cpu_clk_en (cpu_clk_en),
        .per_clk_en (per_clk_en)
    );

    assign wdt_rst_req = wdt_to && (cur_mode == PM_RUN);
    assign mode        = cur_mode;

    AST_WAKE_CPU_GATED: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == PM_WAKE) |-> (!cpu_clk_en && per_clk_en));  // R5
    AST_DONE_CPU_ON: assert property (@(posedge clk) disable iff (rst)
        wake_done |-> cpu_clk_en);  // R5

endmodule

// File: tb/pwr_seq_tb_top.sv
module pwr_seq_tb_top;
    localparam int CLK_T = 10;
    localparam int NI    = 4;
    localparam int DLY   = 4;
    localparam int WDT_P = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sleep_op = 1'b0, clrwdt_op = 1'b0, idle_en = 1'b0;
    logic [NI-1:0] irq_flag = '0, irq_en = '0;
    logic          gie = 1'b0, wdt_en = 1'b0, clk_lost = 1'b0, fscm_en = 1'b0;
    logic          sel_wr = 1'b0;
    logic [1:0]    sel_d = 2'b00;
    logic          cpu_clk_en, per_clk_en, wake_done, vec_req, wdt_rst_req;
    logic [1:0]    mode, clk_src;

    int checks = 0;
    int errors = 0;
    bit done_run = 0;

    always #(CLK_T/2) clk = ~clk;

    pwr_seq #(.N_IRQ(NI), .WAKE_DLY(DLY), .PRE_LIM(4), .POST_LIM(4)) dut_i (
        .clk(clk), .rst(rst), .sleep_op(sleep_op), .clrwdt_op(clrwdt_op),
        .idle_en(idle_en), .irq_flag(irq_flag), .irq_en(irq_en), .gie(gie),
        .wdt_en(wdt_en), .clk_lost(clk_lost), .fscm_en(fscm_en),
        .sel_wr(sel_wr), .sel_d(sel_d), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .wake_done(wake_done), .vec_req(vec_req),
        .wdt_rst_req(wdt_rst_req), .mode(mode), .clk_src(clk_src));

    // {idle_en, irq_en[3:0], irq_flag[3:0], gie, expect_wake, expect_vec}
    localparam logic [11:0] TBL [0:7] = '{
        12'b1_0001_0001_1_1_1,
        12'b0_0010_0010_0_1_0,
        12'b1_0100_1000_1_0_0,
        12'b0_1000_1000_1_1_1,
        12'b1_1111_0100_0_1_0,
        12'b0_0000_1111_1_0_0,
        12'b0_1010_0011_1_1_1,
        12'b1_0101_1010_0_0_0
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic do_reset(input logic wdt_on);
        rst = 1'b1; sleep_op = 0; clrwdt_op = 0; irq_flag = '0; irq_en = '0;
        gie = 0; clk_lost = 0; fscm_en = 0; sel_wr = 0; idle_en = 0;
        wdt_en = wdt_on;
        tick(); tick();
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_T * 150000);
        if (!done_run) begin
            checks++; errors++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 / R12: reset state
        do_reset(1'b0);
        tick();
        chk("R1 mode", mode, 0);
        chk("R1 cpu_clk_en", cpu_clk_en, 1);
        chk("R1 per_clk_en", per_clk_en, 1);
        chk("R1 clk_src", clk_src, 0);
        chk("R1 strobes", {wake_done, vec_req, wdt_rst_req}, 0);

        // Table walk: R2, R3, R4, R5, R6, R12
        for (int r = 0; r < 8; r++) begin
            logic [11:0] v;
            int lp;
            v = TBL[r];
            do_reset(1'b0);
            idle_en = v[11]; irq_en = v[10:7]; gie = v[2];
            tick();
            sleep_op = 1'b1;
            tick();
            sleep_op = 1'b0;
            lp = v[11] ? 1 : 2;
            chk(v[11] ? "R2 enter idle" : "R3 enter sleep", mode, lp);
            chk(v[11] ? "R2 cpu gated" : "R3 cpu gated", cpu_clk_en, 0);
            chk(v[11] ? "R2 per running" : "R3 per gated", per_clk_en, v[11] ? 1 : 0);
            irq_flag = v[6:3];
            tick();
            irq_flag = '0;
            if (v[1]) begin
                for (int i = 0; i < DLY; i++) begin
                    chk("R5 wake mode", mode, 3);
                    chk("R5 wake clocks", {cpu_clk_en, per_clk_en}, 1);
                    chk("R5 no early done", wake_done, 0);
                    tick();
                end
                chk("R5 back to run", mode, 0);
                chk("R5 done pulse", wake_done, 1);
                chk("R6 vector", vec_req, v[0]);
                tick();
                chk("R5 done one cycle", wake_done, 0);
                chk("R6 vector one cycle", vec_req, 0);
            end else begin
                for (int i = 0; i < DLY + 2; i++) begin
                    chk("R4 masked flag ignored", mode, lp);
                    chk("R4 no done", wake_done, 0);
                    tick();
                end
            end
        end

        // R10: pending source at sleep keeps run
        do_reset(1'b0);
        irq_en = 4'b0010; irq_flag = 4'b0010; idle_en = 1'b1;
        tick();
        sleep_op = 1'b1;
        tick();
        sleep_op = 1'b0;
        chk("R10 stays run", mode, 0);
        chk("R10 cpu on", cpu_clk_en, 1);
        tick();
        chk("R10 still run", mode, 0);

        // R7: time-out in run after a clear
        do_reset(1'b1);
        clrwdt_op = 1'b1;
        tick();
        clrwdt_op = 1'b0;
        for (int t = 1; t <= WDT_P + 2; t++) begin
            chk("R7 reset request timing", wdt_rst_req, (t == WDT_P + 1) ? 1 : 0);
            tick();
        end

        // R9: clear in the middle restarts the count
        do_reset(1'b1);
        clrwdt_op = 1'b1;
        tick();
        clrwdt_op = 1'b0;
        for (int t = 1; t <= 10; t++) begin
            chk("R9 no early timeout", wdt_rst_req, 0);
            tick();
        end
        clrwdt_op = 1'b1;
        tick();
        clrwdt_op = 1'b0;
        for (int t = 1; t <= WDT_P + 1; t++) begin
            chk("R9 clrwdt restarts", wdt_rst_req, (t == WDT_P + 1) ? 1 : 0);
            tick();
        end

        // R9: clock loss with fail-safe monitoring clears
        do_reset(1'b1);
        fscm_en = 1'b1;
        clrwdt_op = 1'b1;
        tick();
        clrwdt_op = 1'b0;
        for (int t = 1; t <= 10; t++) tick();
        clk_lost = 1'b1;
        tick();
        clk_lost = 1'b0;
        for (int t = 1; t <= WDT_P + 1; t++) begin
            chk("R9 clk_lost with fscm clears", wdt_rst_req, (t == WDT_P + 1) ? 1 : 0);
            tick();
        end

        // R9: clock loss without monitoring has no effect
        do_reset(1'b1);
        clrwdt_op = 1'b1;
        tick();
        clrwdt_op = 1'b0;
        for (int t = 1; t <= 10; t++) tick();
        chk("R9 before clk_lost", wdt_rst_req, 0);
        clk_lost = 1'b1;
        tick();
        clk_lost = 1'b0;
        for (int t = 12; t <= WDT_P + 2; t++) begin
            chk("R9 clk_lost ignored", wdt_rst_req, (t == WDT_P + 1) ? 1 : 0);
            tick();
        end

        // R8: time-out while asleep wakes, no reset, no vector
        do_reset(1'b1);
        gie = 1'b1; idle_en = 1'b0;
        sleep_op = 1'b1;
        tick();
        sleep_op = 1'b0;
        for (int t = 1; t <= WDT_P + 1; t++) begin
            chk("R8 asleep until timeout", mode, 2);
            chk("R8 no reset request", wdt_rst_req, 0);
            tick();
        end
        for (int t = 0; t < DLY; t++) begin
            chk("R8 wake delay", mode, 3);
            tick();
        end
        chk("R8 run after delay", mode, 0);
        chk("R8 done", wake_done, 1);
        chk("R8 no vector", vec_req, 0);

        // R11: clock select kept across wake, forced by reset
        do_reset(1'b0);
        sel_d = 2'b11; sel_wr = 1'b1;
        tick();
        sel_wr = 1'b0;
        chk("R11 select written", clk_src, 3);
        irq_en = 4'b0001; idle_en = 1'b1;
        sleep_op = 1'b1;
        tick();
        sleep_op = 1'b0;
        irq_flag = 4'b0001;
        tick();
        irq_flag = '0;
        for (int t = 0; t < DLY; t++) tick();
        chk("R11 run after wake", mode, 0);
        chk("R11 select unchanged by wake", clk_src, 3);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R11 reset forces internal RC", clk_src, 0);

        done_run = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule